// File: doc/BRIEF.md
# MDIO Management Slave with Extended Byte Space

This block is a management-bus slave. It watches the serial clock (MDC) and data line (MDIO) of a two-wire management bus and takes part in two kinds of frame. Standard frames (opcode 10 read, opcode 01 write) reach a small set of 16-bit PHY registers. They are answered only when the frame's 5-bit PHY address equals the strapped address. Extended frames reuse the opcode 00, which the standard leaves unused. They reach a flat space of 8-bit configuration registers at any strapped address. In these frames the top bit of the PHY address field picks the direction, and its low three bits join the register field to form an 8-bit address.

Both MDC and MDIO are synchronised into the system clock, and every bus bit is taken on a detected MDC rising edge. The slave changes its driven output a few system clocks after that edge. Toward internal logic the block presents a register-bank port: an address, a space flag, write data, and one-cycle read and write strobes, with read data coming back. The serial bus cannot be stalled, so this port has no back-pressure. The bank must accept every strobe in the cycle it is raised. It must present read data on the clock after a read strobe, and the slave captures the data on that clock. The pad is driven through a separate output value and an output enable.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: A frame is recognised only after at least 32 consecutive 1 bits followed by the start pattern 0 then 1. A frame whose preamble has only 31 ones is ignored: no strobe is raised and MDIO is never driven.
- R2: For a standard read (opcode 10) whose PHY address matches `cfg_phy_addr`, the slave leaves the first turnaround bit undriven and drives 0 on the second. It then drives the 16 data bits MSB first and releases MDIO after the last data bit.
- R3: For a standard write (opcode 01) whose PHY address matches, exactly one write strobe is raised. It carries `reg_addr` = {3'b000, register field}, `reg_space_ext` = 0 and all 16 data bits.
- R4: For a standard frame whose PHY address differs from `cfg_phy_addr`, no strobe is raised and MDIO is never driven.
- R5: Only standard registers 0 to 5, 29 and 31 are reached. A standard read of any other register raises no strobe but is still answered with 16 zero bits. A standard write to any other register raises no strobe.
- R6: For an extended read (opcode 00, PHY field bit 4 = 1), `reg_addr` = {PHY bits 2:0, register field} and `reg_space_ext` = 1. The slave answers in the standard turnaround and data timing, with data bits 15:8 forced to zero. PHY bit 3 and `cfg_phy_addr` have no effect.
- R7: For an extended write (opcode 00, PHY field bit 4 = 0), one write strobe is raised. Its `reg_wdata` carries the frame's data bits 7:0 in bits 7:0 and zero in bits 15:8, whatever the frame sent in bits 15:8.
- R8: Extended addresses 0x00 to 0x8D are reached. Above 0x8D, a read raises no strobe and is answered with zeros, and a write raises no strobe.
- R9: Each strobe is one system clock wide, and the two strobes never coincide. The read strobe is raised during the bus bit that carries the last register-address bit, before the turnaround. The write strobe is raised during the last data bit.
- R10: A wrong start pattern (00 after the preamble) sends the slave back to counting preamble ones. The garbage that follows is ignored, and a later well-formed frame is served normally.
- R11: MDIO is released out of reset, outside the read turnaround and data bits, and for frames with opcode 11, which raise no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_phy_addr | input | 5 | Strapped PHY address for standard frames |
| mdc | input | 1 | Management serial clock |
| mdio_i | input | 1 | MDIO value seen at the pad |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | Pad output enable |
| reg_addr | output | 8 | Register address, held from decode to end of frame |
| reg_space_ext | output | 1 | 1 for extended byte space, 0 for standard space |
| reg_wdata | output | 16 | Write data, valid with `reg_wr` |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 16 | Read data, valid on the clock after `reg_rd` |

## Verification
Every bus result is due a fixed delay after an MDC rising edge. The edge passes a two-flop synchroniser and one edge-detect flop, so strobes and changes on the MDIO output appear three to four system clocks after the edge. The bench holds each MDC half period for ten system clocks and looks at the line only at the end of the low phase, just before the next rise, so the value is stable. A per-clock monitor records each strobe along with the bus-bit index it fell in. After each frame the bench compares those indices with the last address bit and the last data bit, and compares counts, addresses and data with a behavioural register model.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  typedef enum logic [2:0] {
    ST_PREAMBLE,
    ST_START,
    ST_OPCODE,
    ST_PHYAD,
    ST_REGAD,
    ST_TURN,
    ST_DATA
  } mdio_state_e;

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;

endpackage

// File: rtl/mdio_edge_sync.sv
module mdio_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc,
  input  logic mdio_i,
  output logic bit_strobe,
  output logic bit_value
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES:0]   clk_pipe;
  logic [SYNC_STAGES-1:0] dat_pipe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_pipe <= '1;
      dat_pipe <= '1;
    end else begin
      clk_pipe <= {clk_pipe[SYNC_STAGES-1:0], mdc};
      dat_pipe <= {dat_pipe[SYNC_STAGES-2:0], mdio_i};
    end
  end

  // data and clock traverse the same number of stages
  assign bit_strobe = clk_pipe[LAST] & ~clk_pipe[LAST+1];
  assign bit_value  = dat_pipe[LAST];

endmodule

// File: rtl/mdio_addr_check.sv
module mdio_addr_check #(
  parameter int REG_W        = 5,
  parameter int EXT_PHY_BITS = 3,
  parameter int EXT_LAST     = 141,
  parameter logic [(2**REG_W)-1:0] STD_MAP = 32'hA000_003F
) (
  input  logic                          is_ext,
  input  logic [EXT_PHY_BITS+REG_W-1:0] addr,
  output logic                          in_range
);

  localparam int ADDR_W = EXT_PHY_BITS + REG_W;

  logic std_ok;
  logic ext_ok;

  always_comb begin
    std_ok   = (addr[ADDR_W-1:REG_W] == '0) && STD_MAP[addr[REG_W-1:0]];
    ext_ok   = (addr <= ADDR_W'(EXT_LAST));
    in_range = is_ext ? ext_ok : std_ok;
  end

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
#(
  parameter int PRE_LEN      = 32,
  parameter int DATA_W       = 16,
  parameter int EXT_DW       = 8,
  parameter int PHY_W        = 5,
  parameter int REG_W        = 5,
  parameter int EXT_PHY_BITS = 3,
  parameter int EXT_LAST     = 141,
  parameter logic [(2**REG_W)-1:0] STD_MAP = 32'hA000_003F
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bit_strobe,
  input  logic                          bit_value,
  input  logic [PHY_W-1:0]              cfg_phy_addr,
  output logic                          mdio_o,
  output logic                          mdio_oe,
  output logic [EXT_PHY_BITS+REG_W-1:0] reg_addr,
  output logic                          reg_space_ext,
  output logic [DATA_W-1:0]             reg_wdata,
  output logic                          reg_wr,
  output logic                          reg_rd,
  input  logic [DATA_W-1:0]             reg_rdata
);

  localparam int ADDR_W = EXT_PHY_BITS + REG_W;
  localparam int CNT_MAX = (PRE_LEN > DATA_W) ? PRE_LEN : DATA_W;
  localparam int CW      = $clog2(CNT_MAX + 1);

  mdio_state_e       state;
  logic [CW-1:0]     cnt;
  logic [1:0]        opcode;
  logic [PHY_W-1:0]  phyad;
  logic [REG_W-1:0]  regad;
  logic [DATA_W-1:0] rx_sr;
  logic [DATA_W-1:0] tx_sr;
  logic              respond;
  logic              wr_armed;
  logic              load_pend;

  // decode of the header, evaluated on the last register-address bit
  logic [REG_W-1:0]  reg_full;
  logic              dec_ext;
  logic              dec_rd;
  logic              dec_wr;
  logic              dec_match;
  logic [ADDR_W-1:0] dec_addr;
  logic              dec_ok;
  logic [DATA_W-1:0] rx_next;

  always_comb begin
    reg_full  = {regad[REG_W-2:0], bit_value};
    dec_ext   = (opcode == OP_EXT);
    dec_rd    = (opcode == OP_READ)  || (dec_ext && phyad[PHY_W-1]);
    dec_wr    = (opcode == OP_WRITE) || (dec_ext && !phyad[PHY_W-1]);
    dec_match = dec_ext || (phyad == cfg_phy_addr);
    dec_addr  = dec_ext ? {phyad[EXT_PHY_BITS-1:0], reg_full}
                        : {{EXT_PHY_BITS{1'b0}}, reg_full};
    rx_next   = {rx_sr[DATA_W-2:0], bit_value};
  end

  mdio_addr_check #(
    .REG_W       (REG_W),
    .EXT_PHY_BITS(EXT_PHY_BITS),
    .EXT_LAST    (EXT_LAST),
    .STD_MAP     (STD_MAP)
  ) u_addr_check (
    .is_ext  (dec_ext),
    .addr    (dec_addr),
    .in_range(dec_ok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= ST_PREAMBLE;
      cnt           <= '0;
      opcode        <= '0;
      phyad         <= '0;
      regad         <= '0;
      rx_sr         <= '0;
      tx_sr         <= '0;
      respond       <= 1'b0;
      wr_armed      <= 1'b0;
      load_pend     <= 1'b0;
      mdio_o        <= 1'b0;
      mdio_oe       <= 1'b0;
      reg_addr      <= '0;
      reg_space_ext <= 1'b0;
      reg_wdata     <= '0;
      reg_wr        <= 1'b0;
      reg_rd        <= 1'b0;
    end else begin
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;
      if (load_pend) begin
        load_pend <= 1'b0;
        tx_sr     <= reg_space_ext ? DATA_W'(reg_rdata[EXT_DW-1:0]) : reg_rdata;
      end
      if (bit_strobe) begin
        unique case (state)
          ST_PREAMBLE: begin
            if (bit_value) begin
              if (cnt != CW'(PRE_LEN)) cnt <= cnt + 1'b1;
            end else if (cnt == CW'(PRE_LEN)) begin
              state <= ST_START;
              cnt   <= '0;
            end else begin
              cnt <= '0;
            end
          end
          ST_START: begin
            cnt   <= '0;
            state <= bit_value ? ST_OPCODE : ST_PREAMBLE;
          end
          ST_OPCODE: begin
            opcode <= {opcode[0], bit_value};
            if (cnt == CW'(1)) begin
              state <= ST_PHYAD;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_PHYAD: begin
            phyad <= {phyad[PHY_W-2:0], bit_value};
            if (cnt == CW'(PHY_W - 1)) begin
              state <= ST_REGAD;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_REGAD: begin
            regad <= reg_full;
            if (cnt == CW'(REG_W - 1)) begin
              state         <= ST_TURN;
              cnt           <= '0;
              reg_addr      <= dec_addr;
              reg_space_ext <= dec_ext;
              respond       <= dec_rd && dec_match;
              wr_armed      <= dec_wr && dec_match && dec_ok;
              reg_rd        <= dec_rd && dec_match && dec_ok;
              load_pend     <= dec_rd && dec_match && dec_ok;
              tx_sr         <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_TURN: begin
            if (cnt == '0) begin
              cnt <= CW'(1);
              if (respond) begin
                mdio_oe <= 1'b1;
                mdio_o  <= 1'b0;
              end
            end else begin
              cnt   <= '0;
              state <= ST_DATA;
              if (respond) begin
                mdio_o <= tx_sr[DATA_W-1];
                tx_sr  <= {tx_sr[DATA_W-2:0], 1'b0};
              end
            end
          end
          ST_DATA: begin
            rx_sr <= rx_next;
            if (cnt == CW'(DATA_W - 1)) begin
              state    <= ST_PREAMBLE;
              cnt      <= '0;
              mdio_oe  <= 1'b0;
              mdio_o   <= 1'b0;
              respond  <= 1'b0;
              wr_armed <= 1'b0;
              if (wr_armed) begin
                reg_wr    <= 1'b1;
                reg_wdata <= reg_space_ext ? DATA_W'(rx_next[EXT_DW-1:0]) : rx_next;
              end
            end else begin
              cnt <= cnt + 1'b1;
              if (respond) begin
                mdio_o <= tx_sr[DATA_W-1];
                tx_sr  <= {tx_sr[DATA_W-2:0], 1'b0};
              end
            end
          end
          default: begin
            state <= ST_PREAMBLE;
            cnt   <= '0;
          end
        endcase
      end
    end
  end

  // R9: strobes are single-cycle and exclusive
  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_wr));
  p_rd_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);
  p_wr_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);
  // R7: upper byte of an extended write is zero
  p_ext_wdata_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_space_ext) |-> (reg_wdata[DATA_W-1:EXT_DW] == '0));
  // R8: no strobe beyond the last extended address
  p_ext_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_wr || reg_rd) && reg_space_ext) |-> (reg_addr <= ADDR_W'(EXT_LAST)));
  // R5: standard strobes only reach mapped registers
  p_std_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((reg_wr || reg_rd) && !reg_space_ext) |-> STD_MAP[reg_addr[REG_W-1:0]]);
  // R2: the first driven bit of a reply is the turnaround zero
  p_ta_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o);
  // R11: line released while the header is being received
  p_idle_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state inside {ST_PREAMBLE, ST_START, ST_OPCODE, ST_PHYAD, ST_REGAD}) |-> !mdio_oe);

endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave #(
  parameter int PRE_LEN      = 32,
  parameter int DATA_W       = 16,
  parameter int EXT_DW       = 8,
  parameter int PHY_W        = 5,
  parameter int REG_W        = 5,
  parameter int EXT_PHY_BITS = 3,
  parameter int EXT_LAST     = 141,
  parameter int SYNC_STAGES  = 2,
  parameter logic [(2**REG_W)-1:0] STD_MAP = 32'hA000_003F
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [PHY_W-1:0]              cfg_phy_addr,
  input  logic                          mdc,
  input  logic                          mdio_i,
  output logic                          mdio_o,
  output logic                          mdio_oe,
  output logic [EXT_PHY_BITS+REG_W-1:0] reg_addr,
  output logic                          reg_space_ext,
  output logic [DATA_W-1:0]             reg_wdata,
  output logic                          reg_wr,
  output logic                          reg_rd,
  input  logic [DATA_W-1:0]             reg_rdata
);

  logic bit_strobe;
  logic bit_value;

  mdio_edge_sync #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .mdc       (mdc),
    .mdio_i    (mdio_i),
    .bit_strobe(bit_strobe),
    .bit_value (bit_value)
  );

  mdio_frame_engine #(
    .PRE_LEN     (PRE_LEN),
    .DATA_W      (DATA_W),
    .EXT_DW      (EXT_DW),
    .PHY_W       (PHY_W),
    .REG_W       (REG_W),
    .EXT_PHY_BITS(EXT_PHY_BITS),
    .EXT_LAST    (EXT_LAST),
    .STD_MAP     (STD_MAP)
  ) u_engine (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_strobe   (bit_strobe),
    .bit_value    (bit_value),
    .cfg_phy_addr (cfg_phy_addr),
    .mdio_o       (mdio_o),
    .mdio_oe      (mdio_oe),
    .reg_addr     (reg_addr),
    .reg_space_ext(reg_space_ext),
    .reg_wdata    (reg_wdata),
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd),
    .reg_rdata    (reg_rdata)
  );

endmodule

// File: tb/mdio_mgmt_slave_tb_top.sv
module mdio_mgmt_slave_tb_top;

  localparam int HALF = 10;
  localparam logic [4:0] MY_PHY = 5'h03;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mdc = 1'b0;
  logic        m_en = 1'b1;
  logic        m_bit = 1'b1;
  logic        line;
  logic        mdio_o, mdio_oe;
  logic [7:0]  reg_addr;
  logic        reg_space_ext;
  logic [15:0] reg_wdata;
  logic        reg_wr, reg_rd;
  logic [15:0] reg_rdata;

  int checks = 0;
  int fails  = 0;
  int cur_bit = 0;
  int rd_cnt, wr_cnt, rd_bit, wr_bit;
  logic [7:0]  rd_addr, wr_addr;
  logic        rd_ext, wr_ext;
  logic [15:0] wr_data;
  logic        oe_seen;

  logic [15:0] bank_std [0:31];
  logic [7:0]  bank_ext [0:255];
  logic [15:0] ref_std  [0:31];
  logic [7:0]  ref_ext  [0:255];

  always #10 clk = ~clk;

  assign line = mdio_oe ? mdio_o : (m_en ? m_bit : 1'b1);

  mdio_mgmt_slave dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_phy_addr (MY_PHY),
    .mdc          (mdc),
    .mdio_i       (line),
    .mdio_o       (mdio_o),
    .mdio_oe      (mdio_oe),
    .reg_addr     (reg_addr),
    .reg_space_ext(reg_space_ext),
    .reg_wdata    (reg_wdata),
    .reg_wr       (reg_wr),
    .reg_rd       (reg_rd),
    .reg_rdata    (reg_rdata)
  );

  // register bank environment: upper byte of extended reads is junk on purpose
  always_comb begin
    if (reg_space_ext) reg_rdata = {8'hC3, bank_ext[reg_addr]};
    else               reg_rdata = bank_std[reg_addr[4:0]];
  end

  always @(posedge clk) begin
    if (reg_wr) begin
      if (reg_space_ext) bank_ext[reg_addr] <= reg_wdata[7:0];
      else               bank_std[reg_addr[4:0]] <= reg_wdata;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // per-clock monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (reg_rd) begin rd_cnt++; rd_bit = cur_bit; rd_addr = reg_addr; rd_ext = reg_space_ext; end
      if (reg_wr) begin wr_cnt++; wr_bit = cur_bit; wr_addr = reg_addr; wr_ext = reg_space_ext;
                        wr_data = reg_wdata; end
      if (reg_rd || reg_wr) chk("R9", "strobes exclusive", {31'd0, reg_rd && reg_wr}, 32'd0);
      if (mdio_oe) oe_seen = 1'b1;
    end
  end

  task automatic send_bit(input logic b, input logic drv, output logic seen);
    cur_bit++;
    m_en  = drv;
    m_bit = b;
    repeat (HALF) @(posedge clk);
    @(negedge clk);
    seen = line;
    mdc = 1'b1;
    repeat (HALF) @(posedge clk);
    @(negedge clk);
    mdc = 1'b0;
  endtask

  task automatic do_frame(input string req, input int pre, input logic [1:0] sof,
                          input logic [1:0] op, input logic [4:0] phy,
                          input logic [4:0] ra, input logic [15:0] wd);
    logic s;
    logic [15:0] got;
    logic ext, rd, wr, match, ok, good, drive, m_read;
    logic [7:0] addr;
    logic [15:0] exp_data;
    int idx_reg, idx_last;
    ext   = (op == 2'b00);
    rd    = (op == 2'b10) || (ext && phy[4]);
    wr    = (op == 2'b01) || (ext && !phy[4]);
    match = ext || (phy == MY_PHY);
    addr  = ext ? {phy[2:0], ra} : {3'b000, ra};
    ok    = ext ? (addr <= 8'h8D) : ((ra <= 5'd5) || ra == 5'd29 || ra == 5'd31);
    good  = (pre >= 32) && (sof == 2'b01);
    drive = good && rd && match;
    exp_data = !ok ? 16'h0 : (ext ? {8'h00, ref_ext[addr]} : ref_std[ra]);
    m_read = (op == 2'b10) || (ext && phy[4]);
    got = '0;
    rd_cnt = 0; wr_cnt = 0; oe_seen = 1'b0;
    send_bit(1'b0, 1'b1, s);
    repeat (pre) send_bit(1'b1, 1'b1, s);
    for (int i = 1; i >= 0; i--) send_bit(sof[i], 1'b1, s);
    for (int i = 1; i >= 0; i--) send_bit(op[i], 1'b1, s);
    for (int i = 4; i >= 0; i--) send_bit(phy[i], 1'b1, s);
    for (int i = 4; i >= 0; i--) send_bit(ra[i], 1'b1, s);
    idx_reg = cur_bit;
    chk(req, "released before turnaround", {31'd0, mdio_oe}, 32'd0);
    if (m_read) begin
      send_bit(1'b1, 1'b0, s);
      send_bit(1'b1, 1'b0, s);
      if (drive) chk(req, "turnaround second bit", {31'd0, s}, 32'd0);
      for (int i = 15; i >= 0; i--) begin
        send_bit(1'b1, 1'b0, s);
        got[i] = s;
      end
    end else begin
      send_bit(1'b1, 1'b1, s);
      send_bit(1'b0, 1'b1, s);
      for (int i = 15; i >= 0; i--) send_bit(wd[i], 1'b1, s);
    end
    idx_last = cur_bit;
    repeat (4) @(negedge clk);
    chk(req, "released after frame", {31'd0, mdio_oe}, 32'd0);
    if (drive) chk(req, "read data", {16'd0, got}, {16'd0, exp_data});
    else       chk(req, "never driven", {31'd0, oe_seen}, 32'd0);
    chk(req, "read strobe count", rd_cnt, (drive && ok) ? 1 : 0);
    if (drive && ok) begin
      chk(req, "read address", {23'd0, rd_ext, rd_addr}, {23'd0, ext, addr});
      chk("R9", "read strobe bit index", rd_bit, idx_reg);
    end
    chk(req, "write strobe count", wr_cnt, (good && wr && match && ok) ? 1 : 0);
    if (good && wr && match && ok) begin
      chk(req, "write address", {23'd0, wr_ext, wr_addr}, {23'd0, ext, addr});
      chk(req, "write data", {16'd0, wr_data}, {16'd0, ext ? {8'h00, wd[7:0]} : wd});
      chk("R9", "write strobe bit index", wr_bit, idx_last);
      if (ext) ref_ext[addr] = wd[7:0];
      else     ref_std[ra] = wd;
    end
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin
      bank_std[i] = 16'(i * 16'h0531 + 16'h00A7);
      ref_std[i]  = 16'(i * 16'h0531 + 16'h00A7);
    end
    for (int i = 0; i < 256; i++) begin
      bank_ext[i] = 8'(i * 29 + 3);
      ref_ext[i]  = 8'(i * 29 + 3);
    end
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R11", "reset oe", {31'd0, mdio_oe}, 32'd0);
    chk("R9", "reset strobes", {30'd0, reg_rd, reg_wr}, 32'd0);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    do_frame("R2", 32, 2'b01, 2'b10, MY_PHY, 5'd1, 16'h0);
    do_frame("R3", 32, 2'b01, 2'b01, MY_PHY, 5'd4, 16'hBEEF);
    do_frame("R2", 40, 2'b01, 2'b10, MY_PHY, 5'd4, 16'h0);
    do_frame("R5", 32, 2'b01, 2'b01, MY_PHY, 5'd29, 16'h1234);
    do_frame("R5", 32, 2'b01, 2'b10, MY_PHY, 5'd31, 16'h0);
    do_frame("R5", 32, 2'b01, 2'b01, MY_PHY, 5'd7, 16'hFFFF);
    do_frame("R5", 32, 2'b01, 2'b10, MY_PHY, 5'd7, 16'h0);
    do_frame("R4", 32, 2'b01, 2'b10, 5'h05, 5'd1, 16'h0);
    do_frame("R4", 32, 2'b01, 2'b01, 5'h05, 5'd2, 16'hAAAA);
    do_frame("R2", 32, 2'b01, 2'b10, MY_PHY, 5'd2, 16'h0);
    do_frame("R7", 32, 2'b01, 2'b00, 5'b01010, 5'b10101, 16'hFF3C);
    do_frame("R6", 32, 2'b01, 2'b00, 5'b10010, 5'b10101, 16'h0);
    do_frame("R6", 32, 2'b01, 2'b00, 5'b11000, 5'b00011, 16'h0);
    do_frame("R8", 32, 2'b01, 2'b00, 5'b00100, 5'b01101, 16'h5A77);
    do_frame("R8", 32, 2'b01, 2'b00, 5'b11100, 5'b01101, 16'h0);
    do_frame("R8", 32, 2'b01, 2'b00, 5'b00100, 5'b01110, 16'h0011);
    do_frame("R8", 32, 2'b01, 2'b00, 5'b10100, 5'b01110, 16'h0);
    do_frame("R1", 31, 2'b01, 2'b10, MY_PHY, 5'd1, 16'h0);
    do_frame("R1", 31, 2'b01, 2'b01, MY_PHY, 5'd0, 16'h4321);
    do_frame("R10", 32, 2'b00, 2'b01, MY_PHY, 5'd3, 16'h0F0F);
    do_frame("R10", 32, 2'b01, 2'b01, MY_PHY, 5'd3, 16'h7E81);
    do_frame("R10", 32, 2'b01, 2'b10, MY_PHY, 5'd3, 16'h0);
    do_frame("R11", 32, 2'b01, 2'b11, MY_PHY, 5'd1, 16'hFFFF);
    do_frame("R2", 32, 2'b01, 2'b10, MY_PHY, 5'd0, 16'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule